// File: doc/BRIEF.md
# UART Modem Status Register with CTS Transmit Gate

This block keeps the modem status register of a 16550-style serial port. It brings four active-low modem lines (clear-to-send, data-set-ready, ring indicator, carrier detect) into the clock domain through a flop chain. It shows their active-high levels in the upper half of an 8-bit status byte. The lower half holds one sticky change flag per line. The CPU reads the byte, and a read strobe clears the flags. Any set flag, when its enable is on, drives a modem status interrupt.

For self-test, a loopback mode takes the four status levels from the modem control outputs instead of the pins. Change detection still runs in this mode, so software can exercise the flags and the interrupt without external wiring. The block also produces a level that lets the transmitter send. The transmitter samples this level only between characters, so a character already on the line always completes.

Top module: `uart_modem_status`

## Requirements
- R1: After reset, with all modem pins high (inactive), `msr_o` reads 0x00, `msr_irq_o` is 0 and `tx_allow_o` is 1.
- R2: Outside loopback, `msr_o` bit 4 is the inverse of CTS pin, bit 5 of DSR, bit 6 of RI and bit 7 of CD. Pin order on `modem_n_i` is bit 0 CTS, 1 DSR, 2 RI, 3 CD. A pin change shows in `msr_o` on the third rising edge after it.
- R3: The change flags for CTS (bit 0), DSR (bit 1) and CD (bit 3) are set by either edge of their status level, in the same cycle the level appears in `msr_o`.
- R4: The RI change flag (bit 2) is set only when the RI status level goes from 1 to 0, which is the RI pin going from low to high. The opposite edge leaves it clear.
- R5: A cycle with `msr_rd_i` high clears all four change flags on that clock edge.
- R6: If a status change arrives on the same edge as a read, the matching flag is set after that edge, and only the other flags are cleared.
- R7: When `mcr_i` bit 4 (loopback) is 1, bit 4 follows `mcr_i` bit 1 (RTS), bit 5 follows bit 0 (DTR), bit 6 follows bit 2 (OP1) and bit 7 follows bit 3 (OP2), one edge after `mcr_i` changes. The pins have no effect.
- R8: In loopback, changes of the looped-back levels set the change flags under the same edge rules as R3 and R4.
- R9: `msr_irq_o` is 1 exactly when `msr_ie_i` is 1 and at least one of `msr_o` bits 0 to 3 is set.
- R10: When `cts_flow_en_i` is 1 and `msr_o` bit 4 is 0, `tx_allow_o` is 0 one edge later. Otherwise `tx_allow_o` is 1 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| modem_n_i | input | 4 | Active-low modem pins: 0 CTS, 1 DSR, 2 RI, 3 CD |
| mcr_i | input | 5 | Modem control: 0 DTR, 1 RTS, 2 OP1, 3 OP2, 4 loopback |
| msr_rd_i | input | 1 | One-cycle read strobe of the status register |
| msr_ie_i | input | 1 | Modem status interrupt enable |
| cts_flow_en_i | input | 1 | Hardware CTS flow control enable |
| msr_o | output | 8 | Status register: bits 3..0 change flags, bits 7..4 levels |
| msr_irq_o | output | 1 | Modem status interrupt |
| tx_allow_o | output | 1 | Transmit permitted, sampled by the transmitter between characters |

## Verification
The assertions assume that `mcr_i`, `msr_rd_i`, `msr_ie_i` and `cts_flow_en_i` come from logic in the same clock domain, and that only the modem pins are asynchronous. The bench drives every input at the falling edge, so each one is stable around the rising edge. It holds each pin level for several cycles so that the synchroniser always passes a clean value. The read strobe is always a single-cycle pulse. The read-and-change collision is produced through loopback, where the timing of the change is exact.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int LINES   = 4;
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_CD  = 3;

    // control register field positions
    localparam int MCR_DTR  = 0;
    localparam int MCR_RTS  = 1;
    localparam int MCR_OP1  = 2;
    localparam int MCR_OP2  = 3;
    localparam int MCR_LOOP = 4;
    localparam int MCR_W    = 5;

    typedef struct packed {
        logic [LINES-1:0] level;
        logic [LINES-1:0] chg;
    } msr_state_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/msr_core.sv
module msr_core
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_n_i,
    input  logic             loop_i,
    input  logic [LINES-1:0] lb_i,
    input  logic             rd_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] chg_o
);
    msr_state_t       st_d, st_q;
    logic [LINES-1:0] eff;
    logic [LINES-1:0] hit;

    always_comb begin
        eff = loop_i ? lb_i : ~pin_n_i;
        for (int i = 0; i < LINES; i++) begin
            if (i == IDX_RI) hit[i] = st_q.level[i] & ~eff[i];
            else             hit[i] = st_q.level[i] ^ eff[i];
        end
        st_d.level = eff;
        st_d.chg   = (st_q.chg & ~{LINES{rd_i}}) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
    assign chg_o   = st_q.chg;

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && eff == level_o) |=> (chg_o == '0));

    // R4
    ri_rise_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_o[IDX_RI] && eff[IDX_RI] && (rd_i || !chg_o[IDX_RI])) |=> !chg_o[IDX_RI]);

    // R3
    cts_edge_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff[IDX_CTS] != level_o[IDX_CTS]) |=> chg_o[IDX_CTS]);

    // R6
    cd_edge_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && eff[IDX_CD] != level_o[IDX_CD]) |=> chg_o[IDX_CD]);
endmodule

// File: rtl/msr_txgate.sv
module msr_txgate (
    input  logic clk,
    input  logic rst_n,
    input  logic flow_en_i,
    input  logic cts_i,
    output logic allow_o
);
    typedef struct packed {
        logic allow;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d.allow = ~flow_en_i | cts_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{allow: 1'b1};
        else        g_q <= g_d;
    end

    assign allow_o = g_q.allow;

    // R10
    tx_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en_i && !cts_i) |=> !allow_o);

    // R10
    tx_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_en_i) |=> allow_o);
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  modem_n_i,
    input  logic [MCR_W-1:0]  mcr_i,
    input  logic              msr_rd_i,
    input  logic              msr_ie_i,
    input  logic              cts_flow_en_i,
    output logic [2*LINES-1:0] msr_o,
    output logic              msr_irq_o,
    output logic              tx_allow_o
);
    logic [LINES-1:0] pin_sync;
    logic [LINES-1:0] lb_vec;
    logic [LINES-1:0] level;
    logic [LINES-1:0] chg;

    msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (modem_n_i),
        .sync_o  (pin_sync)
    );

    always_comb begin
        lb_vec          = '0;
        lb_vec[IDX_CTS] = mcr_i[MCR_RTS];
        lb_vec[IDX_DSR] = mcr_i[MCR_DTR];
        lb_vec[IDX_RI]  = mcr_i[MCR_OP1];
        lb_vec[IDX_CD]  = mcr_i[MCR_OP2];
    end

    msr_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i (pin_sync),
        .loop_i  (mcr_i[MCR_LOOP]),
        .lb_i    (lb_vec),
        .rd_i    (msr_rd_i),
        .level_o (level),
        .chg_o   (chg)
    );

    msr_txgate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_en_i (cts_flow_en_i),
        .cts_i     (level[IDX_CTS]),
        .allow_o   (tx_allow_o)
    );

    assign msr_o     = {level, chg};
    assign msr_irq_o = msr_ie_i & (|chg);

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_ie_i && |msr_o[LINES-1:0]) |-> msr_irq_o);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr_ie_i || msr_o[LINES-1:0] == '0) |-> !msr_irq_o);

    // R7
    loop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_i[MCR_LOOP] && $past(mcr_i[MCR_LOOP]) && $stable(mcr_i))
            |-> (msr_o[2*LINES-1:LINES] == lb_vec));
endmodule

// File: tb/tb_uart_modem_status.sv
module tb_uart_modem_status;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] modem_n;
    logic [4:0] mcr;
    logic       rd, ie, fc_en;
    logic [7:0] msr;
    logic       irq, tx_allow;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_modem_status dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .modem_n_i     (modem_n),
        .mcr_i         (mcr),
        .msr_rd_i      (rd),
        .msr_ie_i      (ie),
        .cts_flow_en_i (fc_en),
        .msr_o         (msr),
        .msr_irq_o     (irq),
        .tx_allow_o    (tx_allow)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        rd = 1'b1;
        tick(1);
        rd = 1'b0;
    endtask

    task automatic t_reset();
        modem_n = 4'hF; mcr = '0; rd = 0; ie = 0; fc_en = 0;
        rst_n = 0;
        tick(3);
        rst_n = 1;
        tick(4);
        check("R1 msr", msr, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 tx_allow", tx_allow, 1);
    endtask

    task automatic t_cts_pin();
        modem_n = 4'b1110;
        tick(2);
        check("R2 not before third edge", msr, 8'h00);
        tick(1);
        check("R2 R3 cts low", msr, 8'h11);
        check("R9 irq masked", irq, 0);
        ie = 1; #1;
        check("R9 irq enabled", irq, 1);
        tick(1);
        do_read();
        check("R5 read clears", msr, 8'h10);
        check("R9 irq after read", irq, 0);
        modem_n = 4'hF;
        tick(4);
        check("R3 cts other edge", msr, 8'h01);
        do_read();
    endtask

    task automatic t_ri_pin();
        modem_n = 4'b1011;
        tick(4);
        check("R4 RI pin falls, no flag", msr, 8'h40);
        modem_n = 4'hF;
        tick(4);
        check("R4 RI pin rises, flag", msr, 8'h04);
        do_read();
    endtask

    task automatic t_dsr_cd();
        modem_n = 4'b0101;
        tick(4);
        check("R2 R3 dsr cd active", msr, 8'hAA);
        do_read();
        modem_n = 4'hF;
        tick(4);
        check("R3 dsr cd released", msr, 8'h0A);
        do_read();
        check("R5 clear all", msr, 8'h00);
    endtask

    task automatic t_flow();
        fc_en = 1;
        tick(2);
        check("R10 cts inactive blocks", tx_allow, 0);
        modem_n = 4'b1110;
        tick(5);
        check("R10 cts active allows", tx_allow, 1);
        modem_n = 4'hF;
        tick(5);
        check("R10 blocks again", tx_allow, 0);
        fc_en = 0;
        tick(2);
        check("R10 disabled allows", tx_allow, 1);
        do_read();
    endtask

    task automatic t_loop();
        mcr = 5'b1_0000;
        tick(2);
        check("R7 loop entry", msr, 8'h00);
        mcr = 5'b1_0010;
        tick(2);
        check("R7 R8 rts to cts", msr, 8'h11);
        modem_n = 4'h0;
        tick(5);
        check("R7 pins ignored", msr, 8'h11);
        do_read();
        mcr = 5'b1_1111;
        tick(2);
        check("R7 R8 dtr op1 op2", msr, 8'hFA);
        do_read();
        check("R5 loop read", msr, 8'hF0);
        rd = 1'b1;
        mcr = 5'b1_1101;
        tick(1);
        rd = 1'b0;
        check("R6 change on read edge kept", msr, 8'hE1);
        mcr = 5'b1_1001;
        tick(2);
        check("R8 op1 falls sets ri flag", msr, 8'hA5);
        do_read();
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_cts_pin();
        t_ri_pin();
        t_dsr_cd();
        t_flow();
        t_loop();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule